// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider Core

This block holds the counting logic of an integer-N frequency synthesizer. The main path counts oscillator ticks through a fixed-modulus prescaler. The prescaler switches between P+1 and P under a swallow counter (A) and a main counter (B), so the oscillator is divided by N = P·B + A. A second path divides reference ticks by R. A phase-frequency comparator watches the two divided edge streams and drives pump-up and pump-down flags toward an external charge pump.

Everything runs on one system clock. The oscillator and the reference arrive as single-cycle tick strobes, and only cycles that carry a tick advance a divider. The prescaler modulus P is an elaboration parameter and may be 16 or 64. The width of the reference ratio follows from P. A, B and R are plain input buses. Each divider samples them only when it ends a cycle. A combinational flag reports a configuration that breaks the ratio rules. A wake input holds both dividers and the comparator cleared.

Top module: `pll_counter_core`

## Requirements
- R1: With A < B, the spacing between consecutive `main_pulse` cycles is P·B + A oscillator ticks. The first A prescaler cycles of each main cycle last P+1 ticks, and the remaining B−A last P ticks.
- R2: Only clock cycles with the matching tick input high advance a divider. With `osc_tick` high every other cycle, the main spacing is 2·(P·B+A) clock cycles. With `ref_tick` held low, no `ref_pulse` and no `pump_dn` appear.
- R3: The spacing between consecutive `ref_pulse` cycles is R reference ticks.
- R4: A, B and R are sampled only in the tick that ends a divider cycle. A change in mid-cycle leaves the running cycle at its old length, and the next cycle uses the new value.
- R5: `pump_up` goes high in the cycle after a main-divider edge and stays high until the clock edge that sees a reference edge, which clears it.
- R6: When both divided edges coincide, or meet an already-set opposite flag, both flags are low afterwards. `pump_up` and `pump_dn` are never high together.
- R7: `cfg_err` is high, in the same cycle as the inputs, exactly when B < 2, R < 2, A ≥ B, or A > P−2.
- R8: With `wake` low, all four pulse and pump outputs stay low and both dividers are cleared. The first tick after `wake` rises produces a divided edge on each path.
- R9: During reset all pulse and pump outputs are low.
- R10: With P = 64, `ref_r` is 12 bits wide. B = 411, A = 16 gives a main spacing of 26320 ticks, and R = 256 gives a reference spacing of 256.
- R11: `pump_dn` goes high in the cycle after a reference edge and stays high until the clock edge that sees a main-divider edge, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake | input | 1 | High to run; low holds dividers and comparator cleared |
| ref_tick | input | 1 | One-cycle reference tick strobe |
| osc_tick | input | 1 | One-cycle oscillator tick strobe |
| main_b | input | B_W (11) | Main counter ratio B |
| main_a | input | A_W (7) | Swallow counter ratio A |
| ref_r | input | R_W (10 for P=16, 12 for P=64) | Reference ratio R |
| cfg_err | output | 1 | Ratio rule violation flag |
| ref_pulse | output | 1 | One-cycle divided reference edge |
| main_pulse | output | 1 | One-cycle divided oscillator edge |
| pump_up | output | 1 | Oscillator leads: raise frequency demand flag |
| pump_dn | output | 1 | Reference leads: lower frequency demand flag |

## Verification
`cfg_err` is combinational, so it is due in the same cycle as the inputs that cause it. `ref_pulse`, `main_pulse`, `pump_up` and `pump_dn` are all registered once and change right after the clock edge that consumed the final tick. The bench drives inputs and samples outputs on falling edges, so every sample falls half a period after the edge that produced it. Divider spacings are measured as counts of falling-edge samples between pulses, and the expected counts come from the bench's own ratio arithmetic. Pump-flag timing is checked at fixed sample indices after wake, such as the 33rd and 41st samples in the lead test.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

  localparam int B_WIDTH = 11;
  localparam int A_WIDTH = 7;

  // Reference ratio field width follows the prescaler modulus.
  function automatic int ref_width(input int p);
    return (p == 64) ? 12 : 10;
  endfunction

  // Prescaler phase counter must hold the value P.
  function automatic int pre_width(input int p);
    return $clog2(p + 1);
  endfunction

  // Oscillator ticks per main-divider cycle.
  function automatic int total_ratio(input int p, input int b, input int a);
    return p * b + a;
  endfunction

  // Ratio rule check: B and R at least 2, A below B and at most P-2.
  function automatic logic cfg_bad(input int p, input int b, input int a,
                                   input int r);
    return (b < 2) || (r < 2) || (a >= b) || (a > p - 2);
  endfunction

endpackage

// File: rtl/synth_ref_div.sv
module synth_ref_div #(
  parameter int R_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           tick,
  input  logic [R_W-1:0] r_in,
  output logic           edge_o
);

  logic [R_W-1:0] remain;
  logic           at_end;

  assign at_end = (remain <= R_W'(1));
  assign edge_o = run && tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (!run) begin
      remain <= '0;
    end else if (tick) begin
      remain <= at_end ? r_in : remain - 1'b1;
    end
  end

  // R2
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (!run || $stable(remain)));

endmodule

// File: rtl/synth_prescaler.sv
module synth_prescaler #(
  parameter int MOD_P = 16,
  parameter int PRE_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic reload,
  input  logic long_cyc,
  output logic wrap
);

  logic [PRE_W-1:0] phase;

  assign wrap = run && tick && (phase == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!run) begin
      phase <= '0;
    end else if (tick) begin
      if (reload) begin
        phase <= long_cyc ? PRE_W'(MOD_P) : PRE_W'(MOD_P - 1);
      end else if (phase != '0) begin
        phase <= phase - 1'b1;
      end
    end
  end

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PRE_W'(MOD_P));

endmodule

// File: rtl/synth_swallow_ctrl.sv
module synth_swallow_ctrl #(
  parameter int B_W = 11,
  parameter int A_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           tick,
  input  logic           pre_wrap,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic           reload,
  output logic           long_cyc,
  output logic           main_edge,
  output logic           primed,
  output logic [A_W-1:0] ld_a,
  output logic [B_W-1:0] ld_b
);

  logic [A_W-1:0] a_left;
  logic [B_W-1:0] b_left;
  logic [A_W-1:0] a_nxt;
  logic [B_W-1:0] b_nxt;
  logic           empty;
  logic           step;

  assign empty     = (b_left == '0);
  assign primed    = !empty;
  assign step      = run && tick && (empty || pre_wrap);
  assign a_nxt     = (a_left != '0) ? a_left - 1'b1 : '0;
  assign b_nxt     = b_left - 1'b1;
  assign main_edge = step && (empty || (b_nxt == '0));
  assign long_cyc  = main_edge ? (a_in != '0) : (a_nxt != '0);
  assign reload    = step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_left <= '0;
      b_left <= '0;
      ld_a   <= '0;
      ld_b   <= '0;
    end else if (!run) begin
      a_left <= '0;
      b_left <= '0;
      ld_a   <= '0;
      ld_b   <= '0;
    end else if (main_edge) begin
      a_left <= a_in;
      b_left <= b_in;
      ld_a   <= a_in;
      ld_b   <= b_in;
    end else if (step) begin
      a_left <= a_nxt;
      b_left <= b_nxt;
    end
  end

  // R2
  swallow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (!run || ($stable(a_left) && $stable(b_left))));

  // R4
  cfg_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !main_edge) |=> (!run || ($stable(ld_a) && $stable(ld_b))));

endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic div_edge,
  input  logic ref_edge,
  output logic up,
  output logic dn
);

  logic up_set;
  logic dn_set;
  logic both;

  assign up_set = up | div_edge;
  assign dn_set = dn | ref_edge;
  assign both   = up_set & dn_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (!run) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up_set & ~both;
      dn <= dn_set & ~both;
    end
  end

  // R5
  up_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up) |-> $past(div_edge));

  // R11
  dn_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn) |-> $past(ref_edge));

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));

  // R8
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!up && !dn));

endmodule

// File: rtl/pll_counter_core.sv
module pll_counter_core
  import synth_div_pkg::*;
#(
  parameter int MOD_P = 16,
  parameter int B_W   = B_WIDTH,
  parameter int A_W   = A_WIDTH,
  parameter int R_W   = ref_width(MOD_P)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wake,
  input  logic           ref_tick,
  input  logic           osc_tick,
  input  logic [B_W-1:0] main_b,
  input  logic [A_W-1:0] main_a,
  input  logic [R_W-1:0] ref_r,
  output logic           cfg_err,
  output logic           ref_pulse,
  output logic           main_pulse,
  output logic           pump_up,
  output logic           pump_dn
);

  localparam int PRE_W = pre_width(MOD_P);

  logic           ref_edge_w;
  logic           main_edge_w;
  logic           pre_wrap_w;
  logic           pre_reload_w;
  logic           long_cyc_w;
  logic           primed_w;
  logic [A_W-1:0] ld_a_w;
  logic [B_W-1:0] ld_b_w;

  assign cfg_err = cfg_bad(MOD_P, int'(main_b), int'(main_a), int'(ref_r));

  synth_ref_div #(.R_W(R_W)) u_ref (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (wake),
    .tick   (ref_tick),
    .r_in   (ref_r),
    .edge_o (ref_edge_w)
  );

  synth_prescaler #(.MOD_P(MOD_P), .PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (wake),
    .tick     (osc_tick),
    .reload   (pre_reload_w),
    .long_cyc (long_cyc_w),
    .wrap     (pre_wrap_w)
  );

  synth_swallow_ctrl #(.B_W(B_W), .A_W(A_W)) u_swl (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (wake),
    .tick      (osc_tick),
    .pre_wrap  (pre_wrap_w),
    .a_in      (main_a),
    .b_in      (main_b),
    .reload    (pre_reload_w),
    .long_cyc  (long_cyc_w),
    .main_edge (main_edge_w),
    .primed    (primed_w),
    .ld_a      (ld_a_w),
    .ld_b      (ld_b_w)
  );

  synth_pfd u_pfd (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (wake),
    .div_edge (main_edge_w),
    .ref_edge (ref_edge_w),
    .up       (pump_up),
    .dn       (pump_dn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_pulse  <= 1'b0;
      main_pulse <= 1'b0;
    end else if (!wake) begin
      ref_pulse  <= 1'b0;
      main_pulse <= 1'b0;
    end else begin
      ref_pulse  <= ref_edge_w;
      main_pulse <= main_edge_w;
    end
  end

  // Tick count since the previous main edge, for the ratio check.
  logic [31:0] osc_since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_since <= '0;
    end else if (!wake || main_edge_w) begin
      osc_since <= '0;
    end else if (osc_tick) begin
      osc_since <= osc_since + 32'd1;
    end
  end

  // R1
  main_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_edge_w && primed_w && (ld_b_w >= B_W'(2)) && (A_W'(ld_a_w) < ld_b_w[A_W-1:0] || ld_b_w >= B_W'(1 << A_W)))
      |-> (int'(osc_since) + 1 == total_ratio(MOD_P, int'(ld_b_w), int'(ld_a_w))));

endmodule

// File: tb/pll_counter_core_tb_top.sv
module pll_counter_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // columns: B, A, R, expected error flag (P = 16)
  localparam int VEC [0:NVEC-1][0:3] = '{
    '{54,   9,  8,    0},
    '{2,    0,  2,    0},
    '{2,    1,  3,    0},
    '{10,   5,  5,    0},
    '{127,  14, 1023, 0},
    '{20,   14, 4,    0},
    '{2047, 0,  2,    0},
    '{5,    5,  8,    1},
    '{1,    0,  8,    1},
    '{10,   3,  1,    1},
    '{20,   15, 4,    1}
  };

  logic clk = 1'b0, rst_n = 1'b0, wake = 1'b0;
  logic ref_tick = 1'b0, osc_tick = 1'b0;
  logic [10:0] b16 = '0, b64 = '0;
  logic [6:0]  a16 = '0, a64 = '0;
  logic [9:0]  r16 = '0;
  logic [11:0] r64 = '0;
  logic err16, rp16, mp16, up16, dn16;
  logic err64, rp64, mp64, up64, dn64;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_counter_core #(.MOD_P(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .wake(wake), .ref_tick(ref_tick),
    .osc_tick(osc_tick), .main_b(b16), .main_a(a16), .ref_r(r16),
    .cfg_err(err16), .ref_pulse(rp16), .main_pulse(mp16),
    .pump_up(up16), .pump_dn(dn16));

  pll_counter_core #(.MOD_P(64)) dut64_i (
    .clk(clk), .rst_n(rst_n), .wake(wake), .ref_tick(ref_tick),
    .osc_tick(osc_tick), .main_b(b64), .main_a(a64), .ref_r(r64),
    .cfg_err(err64), .ref_pulse(rp64), .main_pulse(mp64),
    .pump_up(up64), .pump_dn(dn64));

  // Bench's own ratio model: A long cycles of P+1, the rest of P.
  function automatic int exp_ratio(input int p, input int b, input int a);
    return (p + 1) * a + p * (b - a);
  endfunction

  task automatic check_eq(input string req, input string what,
                          input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic pick(input int which);
    case (which)
      0: return mp16;
      1: return rp16;
      2: return mp64;
      default: return rp64;
    endcase
  endfunction

  task automatic to_next(input int which, output int cycles);
    cycles = 0;
    do begin @(negedge clk); cycles++; end
    while (!pick(which) && cycles < 70000);
  endtask

  task automatic gap(input int which, output int cycles);
    int guard = 0;
    while (!pick(which) && guard < 70000) begin @(negedge clk); guard++; end
    to_next(which, cycles);
  endtask

  task automatic sleep_then_wake();
    wake = 1'b0;
    repeat (2) @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int c, ups, dns, first, second;
    b64 = 11'd411; a64 = 7'd16; r64 = 12'd256;
    ref_tick = 1'b1; osc_tick = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check_eq("R9", "pulses/pumps in reset", {mp16, rp16, up16, dn16}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R7 flag, R1 main spacing, R3 reference spacing
    for (int v = 0; v < NVEC; v++) begin
      wake = 1'b0;
      b16 = 11'(VEC[v][0]); a16 = 7'(VEC[v][1]); r16 = 10'(VEC[v][2]);
      repeat (2) @(negedge clk);
      check_eq("R7", $sformatf("cfg_err vec %0d", v), err16, VEC[v][3]);
      if (VEC[v][3] == 0) begin
        wake = 1'b1;
        gap(0, c);
        check_eq("R1", $sformatf("main spacing vec %0d", v), c,
                 exp_ratio(16, VEC[v][0], VEC[v][1]));
        gap(1, c);
        check_eq("R3", $sformatf("ref spacing vec %0d", v), c, VEC[v][2]);
      end
    end

    // R8 wake low: outputs quiet while ticks run
    wake = 1'b0; b16 = 11'd2; a16 = 7'd0; r16 = 10'd2;
    c = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mp16 || rp16 || up16 || dn16) c++;
    end
    check_eq("R8", "active outputs while asleep", c, 0);
    wake = 1'b1;
    @(negedge clk);
    check_eq("R8", "main edge on first tick after wake", mp16, 1);
    check_eq("R8", "ref edge on first tick after wake", rp16, 1);

    // R4 mid-cycle change of B
    sleep_then_wake();
    check_eq("R4", "first main pulse", mp16, 1);
    c = 0;
    do begin
      @(negedge clk); c++;
      if (c == 10) b16 = 11'd4;
    end while (!mp16 && c < 200);
    check_eq("R4", "running cycle keeps old ratio", c, 32);
    to_next(0, c);
    check_eq("R4", "next cycle takes new ratio", c, 64);

    // R5 oscillator leads: N=32, R=40
    wake = 1'b0; b16 = 11'd2; a16 = 7'd0; r16 = 10'd40;
    repeat (2) @(negedge clk);
    wake = 1'b1;
    ups = 0; dns = 0;
    for (int i = 1; i <= 50; i++) begin
      @(negedge clk);
      ups += int'(up16); dns += int'(dn16);
      if (i == 33) check_eq("R5", "pump_up set after main edge", up16, 1);
      if (i == 41) check_eq("R5", "pump_up cleared by ref edge", up16, 0);
    end
    check_eq("R5", "pump_up high cycles", ups, 8);
    check_eq("R5", "pump_dn idle when osc leads", dns, 0);

    // R11 reference leads: N=48, R=40
    wake = 1'b0; b16 = 11'd3; a16 = 7'd0; r16 = 10'd40;
    repeat (2) @(negedge clk);
    wake = 1'b1;
    ups = 0; dns = 0;
    for (int i = 1; i <= 50; i++) begin
      @(negedge clk);
      ups += int'(up16); dns += int'(dn16);
      if (i == 41) check_eq("R11", "pump_dn set after ref edge", dn16, 1);
      if (i == 49) check_eq("R11", "pump_dn cleared by main edge", dn16, 0);
    end
    check_eq("R11", "pump_dn high cycles", dns, 8);
    check_eq("R11", "pump_up idle when ref leads", ups, 0);

    // R6 coincident edges: N=32, R=32
    wake = 1'b0; b16 = 11'd2; a16 = 7'd0; r16 = 10'd32;
    repeat (2) @(negedge clk);
    wake = 1'b1;
    c = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (up16 || dn16) c++;
    end
    check_eq("R6", "pump activity with aligned edges", c, 0);

    // R2 half-rate oscillator ticks: N=33 -> 66 cycles; ref ticks off
    wake = 1'b0; b16 = 11'd2; a16 = 7'd1; r16 = 10'd2;
    ref_tick = 1'b0;
    repeat (2) @(negedge clk);
    wake = 1'b1;
    first = -1; second = -1; c = 0;
    for (int i = 0; i < 200; i++) begin
      osc_tick = ~osc_tick;
      @(negedge clk);
      if (mp16) begin
        if (first < 0) first = i; else if (second < 0) second = i;
      end
      if (rp16 || dn16) c++;
    end
    check_eq("R2", "main spacing at half tick rate", second - first, 66);
    check_eq("R2", "ref/dn activity with no ref ticks", c, 0);
    osc_tick = 1'b1; ref_tick = 1'b1;

    // R10 modulus 64 variant
    check_eq("R10", "cfg_err for B=411 A=16 R=256", err64, 0);
    sleep_then_wake();
    gap(2, c);
    check_eq("R10", "main spacing P=64", c, 26320);
    gap(3, c);
    check_eq("R10", "ref spacing P=64", c, 256);
    a64 = 7'd62; b64 = 11'd100;
    #1 check_eq("R7", "A=62 legal at P=64", err64, 0);
    a64 = 7'd63;
    #1 check_eq("R7", "A=63 illegal at P=64", err64, 1);
    r64 = 12'd4095; a64 = 7'd0;
    #1 check_eq("R10", "12-bit ref field max legal", err64, 0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule